// File: doc/BRIEF.md
# Address-Filtering Bit-Synchronous Frame Receiver

This block takes a recovered serial bit stream, one bit per `rx_valid` strobe, and turns it into buffer writes. It finds frame boundaries by watching for the flag pattern and deletes the zeros that a transmitter inserts for transparency. It packs the remaining bits into bytes and checks the 16-bit frame check sequence at the tail of each frame. Only frames whose first byte equals the programmed station address are passed on.

Every stored byte goes out as an 11-bit entry through a single-cycle write strobe. The entry carries three status bits: end-of-frame, CRC error and abort. Software reading the buffer therefore learns where a frame ended, and how, without a separate status path. Two single-cycle interrupt pulses report checksum failures and receiver aborts.

Stored output lags the line by three bytes. The two check bytes are never written. Holding three bytes lets the status be attached to the real last data byte. When the closing flag shows that a frame is too short to hold an address and a check sequence, the frame is dropped.

Top module: `hdlc_addr_rx`

## Requirements
- R1: A flag is the raw pattern 0,1,1,1,1,1,1,0. Bits between two flags form the frame, least significant bit of each byte first. Stored bytes leave in line order.
- R2: A raw 0 that follows exactly five consecutive raw 1s is deleted and never appears in stored data.
- R3: The first byte of a frame is compared with `own_addr`. A frame whose first byte differs produces no buffer write and no interrupt.
- R4: Entry layout is bits [7:0] data byte, bit 8 end-of-frame, bit 9 CRC error, bit 10 abort. Only the final entry of a frame has bit 8 set. Bits 9 and 10 are never both set.
- R5: The check covers every frame bit, address through check bytes, using the reflected CCITT polynomial 0x8408 with seed 0xFFFF. A correct frame leaves a residue of 0xF0B8. The two check bytes are not stored, and the last stored byte of a good frame carries only the end-of-frame bit.
- R6: A matched frame whose residue is wrong has its last entry written with bits 8 and 9 set. `irq_crc_err` pulses for one cycle in the same cycle as that write.
- R7: Seven consecutive raw 1s inside an open frame pulse `irq_abort` once. For a matched frame, entries already written stay. The oldest completed byte not yet written, if any, is written with bits 8 and 10 set, and all later bytes are discarded. Because output lags the line, the byte sent just before the abort run is never completed. After an abort, nothing is received until a flag arrives.
- R8: A frame that ends with fewer than three complete bytes produces no write and no interrupt.
- R9: Repeated flags, including flags whose leading 0 is the trailing 0 of the previous flag, open empty frames that produce nothing. The next frame after them is received normally.
- R10: During and after reset, with no traffic, `buf_wr`, `irq_crc_err` and `irq_abort` are low.
- R11: An unbroken run of 1s longer than seven gives a single abort pulse.
- R12: A matched frame whose closing flag arrives with a partial byte pending is reported as a CRC error, exactly as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A line bit is present on `rx_bit` this cycle |
| rx_bit | input | 1 | Recovered line bit |
| own_addr | input | 8 | Station address frames are matched against |
| buf_wr | output | 1 | Write strobe for the receive buffer |
| buf_data | output | 11 | Entry: data byte plus end, CRC-error and abort flags |
| irq_crc_err | output | 1 | One-cycle pulse on a bad frame check |
| irq_abort | output | 1 | One-cycle pulse on a receiver abort |

## Verification
The bench targets data bytes of 0xFF and 0x7E, which force stuffed zeros. A destuffer that deleted the wrong zero, or none, would corrupt those bytes or close the frame early. It sends frames made of only an address and a check sequence, two-byte runts and a frame with three stray bits before the flag. Misplaced end-of-frame marking, stored check bytes or a silent partial-byte frame all show up in the entry stream. Abort runs longer than seven ones are placed after several bytes, after one byte and before the address completes. These catch wrong choice of the abort-tagged byte, duplicated abort pulses and failure to hunt for the next flag. Random traffic mixes foreign addresses, corrupted checks, shared-zero flags and idle gaps on the valid strobe.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   localparam int OCTET_W = 8;
   localparam int CRC_W   = 16;

   typedef struct packed {
      logic                abort;
      logic                crc_bad;
      logic                eof;
      logic [OCTET_W-1:0]  data;
   } rx_entry_t;

   localparam int ENTRY_W = $bits(rx_entry_t);

   // one bit of a reflected (LSB-first) CRC update
   function automatic logic [CRC_W-1:0] crc_bit_step(input logic [CRC_W-1:0] cur,
                                                     input logic             din,
                                                     input logic [CRC_W-1:0] poly);
      logic fb;
      fb = cur[0] ^ din;
      return (cur >> 1) ^ (fb ? poly : '0);
   endfunction

endpackage

// File: rtl/hrx_destuff.sv
module hrx_destuff #(
   parameter int STUFF_RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_vld,
   input  logic in_bit,
   output logic out_vld,
   output logic out_bit,
   output logic flag_hit,
   output logic abort_hit
);
   localparam int FLAG_RUN  = STUFF_RUN + 1;
   localparam int ABORT_RUN = STUFF_RUN + 2;
   localparam int LAG       = FLAG_RUN + 1;       // flag bits already entered when the flag is seen
   localparam int RUN_W     = $clog2(ABORT_RUN + 1);
   localparam int FILL_W    = $clog2(LAG + 1);

   initial begin
      assert (STUFF_RUN >= 2) else $error("STUFF_RUN must be at least 2");
   end

   logic [RUN_W-1:0]  run_q;
   logic [LAG-1:0]    line_q;
   logic [FILL_W-1:0] fill_q;
   logic              is_stuff, is_flag, is_abort, take;

   always_comb begin
      is_stuff = in_vld && !in_bit && (run_q == RUN_W'(STUFF_RUN));
      is_flag  = in_vld && !in_bit && (run_q == RUN_W'(FLAG_RUN));
      is_abort = in_vld &&  in_bit && (run_q == RUN_W'(FLAG_RUN));
      take     = in_vld && ((in_bit && (run_q < RUN_W'(FLAG_RUN))) ||
                            (!in_bit && !is_stuff && !is_flag));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q     <= '0;
         line_q    <= '0;
         fill_q    <= '0;
         out_vld   <= 1'b0;
         out_bit   <= 1'b0;
         flag_hit  <= 1'b0;
         abort_hit <= 1'b0;
      end else begin
         out_vld   <= 1'b0;
         flag_hit  <= is_flag;
         abort_hit <= is_abort;
         if (in_vld) begin
            if (!in_bit)
               run_q <= '0;
            else if (run_q != RUN_W'(ABORT_RUN))
               run_q <= run_q + 1'b1;
         end
         if (is_flag || is_abort) begin
            fill_q <= '0;
         end else if (take) begin
            line_q <= {line_q[LAG-2:0], in_bit};
            if (fill_q == FILL_W'(LAG)) begin
               out_vld <= 1'b1;
               out_bit <= line_q[LAG-1];
            end else begin
               fill_q <= fill_q + 1'b1;
            end
         end
      end
   end

   p_stuffed_zero_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_bit && run_q == RUN_W'(STUFF_RUN)) |=> (!out_vld && !flag_hit))
      else $error("stuffed zero leaked");

   p_flag_ends_in_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      flag_hit |-> $past(in_vld && !in_bit))
      else $error("flag without closing zero");

   p_no_flag_after_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_hit |=> !flag_hit)
      else $error("flag directly after abort");

endmodule

// File: rtl/hrx_crc.sv
module hrx_crc #(
   parameter logic [15:0] POLY = 16'h8408,
   parameter logic [15:0] SEED = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        step,
   input  logic        din,
   output logic [15:0] crc_q
);
   import hdlc_rx_pkg::*;

   initial begin
      assert (CRC_W == 16) else $error("checker is sized for a 16-bit sequence");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         crc_q <= SEED;
      else if (clr)
         crc_q <= SEED;
      else if (step)
         crc_q <= crc_bit_step(crc_q, din, POLY);
   end

endmodule

// File: rtl/hrx_framer.sv
module hrx_framer
   import hdlc_rx_pkg::*;
#(
   parameter int          FCS_BYTES = 2,
   parameter logic [15:0] RESIDUE   = 16'hF0B8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_vld,
   input  logic               bit_d,
   input  logic               flag_hit,
   input  logic               abort_hit,
   input  logic [15:0]        crc_q,
   input  logic [OCTET_W-1:0] own_addr,
   output logic               wr_en,
   output rx_entry_t          wr_entry,
   output logic               irq_crc,
   output logic               irq_abort
);
   localparam int HOLD  = FCS_BYTES + 1;
   localparam int CNT_W = $clog2(HOLD + 1);
   localparam int BIT_W = $clog2(OCTET_W);

   initial begin
      assert (FCS_BYTES >= 1) else $error("FCS_BYTES must be positive");
   end

   logic                          in_frame, addr_ok;
   logic [BIT_W-1:0]              bit_cnt;
   logic [OCTET_W-1:0]            shreg, new_byte, abort_pick;
   logic [CNT_W-1:0]              n_bytes;
   logic [HOLD-1:0][OCTET_W-1:0]  hold;
   logic                          byte_done, crc_bad;

   always_comb begin
      new_byte  = {bit_d, shreg[OCTET_W-1:1]};
      byte_done = bit_vld && in_frame && !flag_hit && !abort_hit &&
                  (bit_cnt == BIT_W'(OCTET_W - 1));
      crc_bad   = (crc_q != RESIDUE) || (bit_cnt != '0);
   end

   // oldest completed, unwritten byte
   always_comb begin
      abort_pick = '0;
      for (int i = 0; i < HOLD; i++)
         if (n_bytes == CNT_W'(i + 1))
            abort_pick = hold[i];
   end

   generate
      if (HOLD > 1) begin : g_hold_chain
         always_ff @(posedge clk) begin
            if (!rst_n)         hold <= '0;
            else if (byte_done) hold <= {hold[HOLD-2:0], new_byte};
         end
      end else begin : g_hold_single
         always_ff @(posedge clk) begin
            if (!rst_n)         hold <= '0;
            else if (byte_done) hold <= new_byte;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         addr_ok   <= 1'b0;
         bit_cnt   <= '0;
         shreg     <= '0;
         n_bytes   <= '0;
         wr_en     <= 1'b0;
         wr_entry  <= '0;
         irq_crc   <= 1'b0;
         irq_abort <= 1'b0;
      end else begin
         wr_en     <= 1'b0;
         irq_crc   <= 1'b0;
         irq_abort <= 1'b0;
         if (abort_hit) begin
            if (in_frame) begin
               irq_abort <= 1'b1;
               if (addr_ok && n_bytes != '0) begin
                  wr_en    <= 1'b1;
                  wr_entry <= '{abort: 1'b1, crc_bad: 1'b0, eof: 1'b1, data: abort_pick};
               end
            end
            in_frame <= 1'b0;
            addr_ok  <= 1'b0;
            bit_cnt  <= '0;
            n_bytes  <= '0;
         end else if (flag_hit) begin
            if (in_frame && addr_ok && n_bytes == CNT_W'(HOLD)) begin
               wr_en    <= 1'b1;
               wr_entry <= '{abort: 1'b0, crc_bad: crc_bad, eof: 1'b1, data: hold[HOLD-1]};
               irq_crc  <= crc_bad;
            end
            in_frame <= 1'b1;
            addr_ok  <= 1'b0;
            bit_cnt  <= '0;
            n_bytes  <= '0;
         end else if (bit_vld && in_frame) begin
            shreg   <= new_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
               if (n_bytes == '0)
                  addr_ok <= (new_byte == own_addr);
               if (n_bytes == CNT_W'(HOLD)) begin
                  if (addr_ok) begin
                     wr_en    <= 1'b1;
                     wr_entry <= '{abort: 1'b0, crc_bad: 1'b0, eof: 1'b0, data: hold[HOLD-1]};
                  end
               end else begin
                  n_bytes <= n_bytes + 1'b1;
               end
            end
         end
      end
   end

   p_write_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(addr_ok))
      else $error("write from unmatched frame");

   p_status_implies_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_entry.crc_bad || wr_entry.abort)) |-> wr_entry.eof)
      else $error("status bit without end mark");

   p_crc_irq_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_crc |-> (wr_en && wr_entry.crc_bad))
      else $error("crc interrupt without tagged write");

   p_abort_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_abort |=> !irq_abort)
      else $error("abort pulse repeated");

endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
   import hdlc_rx_pkg::*;
#(
   parameter int          STUFF_RUN   = 5,
   parameter int          FCS_BYTES   = 2,
   parameter logic [15:0] CRC_POLY    = 16'h8408,
   parameter logic [15:0] CRC_SEED    = 16'hFFFF,
   parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic               rx_bit,
   input  logic [OCTET_W-1:0] own_addr,
   output logic               buf_wr,
   output logic [ENTRY_W-1:0] buf_data,
   output logic               irq_crc_err,
   output logic               irq_abort
);
   logic        d_vld, d_bit, f_hit, a_hit;
   logic [15:0] crc_val;
   rx_entry_t   entry;

   hrx_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (rx_valid),
      .in_bit    (rx_bit),
      .out_vld   (d_vld),
      .out_bit   (d_bit),
      .flag_hit  (f_hit),
      .abort_hit (a_hit)
   );

   hrx_crc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (f_hit | a_hit),
      .step  (d_vld),
      .din   (d_bit),
      .crc_q (crc_val)
   );

   hrx_framer #(.FCS_BYTES(FCS_BYTES), .RESIDUE(CRC_RESIDUE)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld   (d_vld),
      .bit_d     (d_bit),
      .flag_hit  (f_hit),
      .abort_hit (a_hit),
      .crc_q     (crc_val),
      .own_addr  (own_addr),
      .wr_en     (buf_wr),
      .wr_entry  (entry),
      .irq_crc   (irq_crc_err),
      .irq_abort (irq_abort)
   );

   assign buf_data = entry;

   p_entry_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr |-> $onehot0({buf_data[10], buf_data[9]}))
      else $error("entry tagged both abort and crc error");

endmodule

// File: tb/tb_hdlc_addr_rx.sv
module tb_hdlc_addr_rx;

   logic        clk = 1'b0;
   logic        rst_n, rx_valid, rx_bit;
   logic [7:0]  own_addr;
   logic        buf_wr, irq_crc_err, irq_abort;
   logic [10:0] buf_data;

   always #10 clk = ~clk;

   hdlc_addr_rx dut (
      .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_bit (rx_bit),
      .own_addr (own_addr), .buf_wr (buf_wr), .buf_data (buf_data),
      .irq_crc_err (irq_crc_err), .irq_abort (irq_abort)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   bit txq[$];
   int tx_ones = 0;
   logic [10:0] exp_q[$], got_q[$];
   int exp_crc = 0, got_crc = 0, exp_abt = 0, got_abt = 0, bad_couple = 0;

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (buf_wr) got_q.push_back(buf_data);
         if (irq_crc_err) begin
            got_crc++;
            if (!(buf_wr && buf_data[9] && buf_data[8])) bad_couple++;
         end
         if (irq_abort) got_abt++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] fcs_of(input logic [7:0] b[$]);
      logic [15:0] c = 16'hFFFF;
      foreach (b[i])
         for (int k = 0; k < 8; k++) begin
            logic fb = c[0] ^ b[i][k];
            c = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
         end
      return ~c;
   endfunction

   task automatic push_flag();
      txq.push_back(1'b0);
      repeat (6) txq.push_back(1'b1);
      txq.push_back(1'b0);
      tx_ones = 0;
   endtask

   task automatic push_shared_flag();   // reuses the previous closing zero
      repeat (6) txq.push_back(1'b1);
      txq.push_back(1'b0);
      tx_ones = 0;
   endtask

   task automatic push_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         txq.push_back(v[i]);
         if (v[i]) begin
            tx_ones++;
            if (tx_ones == 5) begin
               txq.push_back(1'b0);
               tx_ones = 0;
            end
         end else tx_ones = 0;
      end
   endtask

   task automatic push_body(input logic [7:0] b[$], input bit corrupt);
      logic [15:0] f = fcs_of(b);
      if (corrupt) f ^= 16'h0100;
      foreach (b[i]) push_byte(b[i]);
      push_byte(f[7:0]);
      push_byte(f[15:8]);
   endtask

   task automatic expect_frame(input logic [7:0] b[$], input bit bad);
      if (b[0] == own_addr) begin
         foreach (b[i]) begin
            bit last = (i == b.size() - 1);
            exp_q.push_back({1'b0, bad && last, last, b[i]});
         end
         if (bad) exp_crc++;
      end
   endtask

   task automatic play();
      while (txq.size() > 0) begin
         @(negedge clk);
         if ($urandom % 6 == 0) rx_valid = 1'b0;
         else begin
            rx_valid = 1'b1;
            rx_bit   = txq.pop_front();
         end
      end
      @(negedge clk) rx_valid = 1'b0;
      repeat (24) @(negedge clk);
   endtask

   task automatic compare(input string req);
      int n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
      check(got_q.size() == exp_q.size(), req, "entry count", got_q.size(), exp_q.size());
      for (int i = 0; i < n; i++)
         check(got_q[i] == exp_q[i], req, $sformatf("entry %0d", i), got_q[i], exp_q[i]);
      check(got_crc == exp_crc, req, "crc irq count (R6)", got_crc, exp_crc);
      check(got_abt == exp_abt, req, "abort irq count (R7)", got_abt, exp_abt);
      check(bad_couple == 0, req, "crc irq without tagged write (R6)", bad_couple, 0);
      got_q.delete(); exp_q.delete();
      got_crc = 0; exp_crc = 0; got_abt = 0; exp_abt = 0; bad_couple = 0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] fr[$];
      void'($urandom(32'd4242));
      rst_n = 1'b0; rx_valid = 1'b0; rx_bit = 1'b0; own_addr = 8'hA5;
      repeat (4) @(negedge clk);
      check({buf_wr, irq_crc_err, irq_abort} == 3'b000, "R10", "outputs in reset",
            {buf_wr, irq_crc_err, irq_abort}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check({buf_wr, irq_crc_err, irq_abort} == 3'b000, "R10", "outputs idle after reset",
            {buf_wr, irq_crc_err, irq_abort}, 0);

      // R9: idle flags, some sharing a zero
      push_flag(); push_flag(); push_shared_flag(); push_shared_flag();
      play(); compare("R9");

      // R5/R8 boundary: address plus check bytes only
      fr = '{8'hA5}; push_body(fr, 0); push_flag(); expect_frame(fr, 0);
      play(); compare("R5");

      // R8: runts of one and two bytes
      push_byte(8'hA5); push_byte(8'h12); push_flag();
      push_byte(8'hA5); push_flag();
      play(); compare("R8");

      // R2: bytes forcing stuffed zeros
      fr = '{8'hA5, 8'hFF, 8'h7E, 8'hFF, 8'h1F, 8'hF8}; push_body(fr, 0); push_flag();
      expect_frame(fr, 0); play(); compare("R2");

      // R3: foreign address, then a matched frame
      fr = '{8'h5A, 8'h01, 8'h02}; push_body(fr, 1); push_flag(); expect_frame(fr, 1);
      fr = '{8'hA5, 8'h33}; push_body(fr, 0); push_flag(); expect_frame(fr, 0);
      play(); compare("R3");

      // R6: corrupted check sequence
      fr = '{8'hA5, 8'h10, 8'h20}; push_body(fr, 1); push_flag(); expect_frame(fr, 1);
      play(); compare("R6");

      // R12: three stray bits before the closing flag
      fr = '{8'hA5, 8'h44}; push_body(fr, 0);
      txq.push_back(1'b0); txq.push_back(1'b1); txq.push_back(1'b0);
      push_flag();
      exp_q.push_back({3'b000, 8'hA5}); exp_q.push_back({3'b011, 8'h44}); exp_crc++;
      play(); compare("R12");

      // R7/R11: long abort after five bytes, junk, then recovery
      push_byte(8'hA5); push_byte(8'hB1); push_byte(8'hB2); push_byte(8'hB3); push_byte(8'h00);
      repeat (12) txq.push_back(1'b1);
      exp_q.push_back({3'b000, 8'hA5}); exp_q.push_back({3'b101, 8'hB1}); exp_abt++;
      fr = '{8'hA5, 8'h77}; push_body(fr, 0); push_flag();     // unopened: ignored
      fr = '{8'hA5, 8'h5E}; push_body(fr, 0); push_flag(); expect_frame(fr, 0);
      play(); compare("R11");

      // R7: abort with only the address complete, and before the address completes
      push_byte(8'hA5); push_byte(8'hC3);
      repeat (7) txq.push_back(1'b1);
      exp_q.push_back({3'b101, 8'hA5}); exp_abt++;
      push_flag();
      txq.push_back(1'b0); txq.push_back(1'b1); txq.push_back(1'b0); txq.push_back(1'b0);
      repeat (9) txq.push_back(1'b1);
      exp_abt++;
      push_flag();
      play(); compare("R7");

      // R1/R4: random traffic
      for (int n = 0; n < 40; n++) begin
         int len = $urandom % 5;
         bit bad = ($urandom % 5 == 0);
         fr = '{};
         fr.push_back(($urandom % 4 == 0) ? 8'($urandom) : own_addr);
         for (int k = 0; k < len; k++)
            fr.push_back(($urandom % 3 == 0) ? 8'hFF : 8'($urandom));
         push_body(fr, bad);
         push_flag();
         if ($urandom % 4 == 0) push_shared_flag();
         expect_frame(fr, bad);
      end
      play(); compare("R1");

      done = 1;
      summary();
      $finish;
   end

endmodule